// File: doc/BRIEF.md
# Descriptor Auto-Poll Timer

This block raises periodic poll requests that tell a DMA engine to fetch its transmit or receive descriptor ring again, so software does not have to write a poll register each time. It has two independent channels, one for transmit (TX) and one for receive (RX). Each channel has a 4-bit period counted in units of a cycle. A cycle is a fixed number of line bit-time strobes, either a normal or a long count, chosen per channel. A period of zero turns automatic polling off for that channel.

The period is measured in bit-time strobes, so it scales with line speed. At 100 Mb/s a normal cycle is 5.12 µs and a long cycle is 81.92 µs; at 10 Mb/s both are ten times longer. Software can also fire a manual poll demand per channel. This raises the request at once and starts that channel's period again.

Each request is the valid side of a valid/ready pair. The DMA engine accepts it by driving the matching acknowledge, which is the ready side. A request stays high while it is not acknowledged. Timer expirations that arrive while a request is already pending are merged into it and are not queued. The acknowledge has no effect while its request is low.

Top module: `desc_autopoll_timer`

## Requirements
- R1: After reset both requests are low, TX polling is off (period 0), and RX has period 1 with normal cycle length.
- R2: With a non-zero RX period P, `rx_poll_req` rises on the clock after the bit-time strobe that completes P full RX cycles, counted from the last restart.
- R3: The TX channel follows the same period rule as RX, using `cfg_tx_period` and `cfg_tx_long`, and runs independently of RX.
- R4: A cycle is NORM_BITS bit-time strobes (default 512) when the channel's long-cycle bit is 0, and LONG_BITS strobes (default 8192) when it is 1.
- R5: A period value of 0 stops all timer-driven requests for that channel.
- R6: A manual demand pulse sets the channel's request on the next clock and restarts that channel's cycle and period counts from zero.
- R7: A raised request stays high until it is sampled high together with its acknowledge. It then drops on the next clock, unless a demand or an expiration sets it again in that same cycle.
- R8: An expiration that occurs while the request is already high adds no further request. Exactly one request is seen until it is acknowledged.
- R9: A configuration write (`cfg_we` high) loads all four fields on the next clock and restarts both channels' counts from zero.
- R10: The counts advance only in cycles where `bit_tick` is high. Without strobes no expiration happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Loads the four configuration fields and restarts both channels |
| cfg_tx_period | input | 4 | TX period in cycles; 0 turns TX polling off |
| cfg_tx_long | input | 1 | 1 selects the long TX cycle |
| cfg_rx_period | input | 4 | RX period in cycles; 0 turns RX polling off |
| cfg_rx_long | input | 1 | 1 selects the long RX cycle |
| bit_tick | input | 1 | One-clock strobe per line bit time |
| tx_demand | input | 1 | Manual TX poll demand pulse |
| rx_demand | input | 1 | Manual RX poll demand pulse |
| tx_poll_req | output | 1 | TX poll request (valid) |
| tx_poll_ack | input | 1 | TX acknowledge (ready) |
| rx_poll_req | output | 1 | RX poll request (valid) |
| rx_poll_ack | input | 1 | RX acknowledge (ready) |

## Verification
Every result appears exactly one clock after the edge that causes it. A demand, an expiring strobe or an accepted handshake at edge N shows on the request output after edge N. A configuration write at edge N takes effect on the counts from edge N+1. The bench drives inputs on falling edges and runs a behavioural model on rising edges. It compares both request outputs with the model at every falling edge, half a period after the edge that changed them. Directed checks for each feature sample at the same falling edges and count the expected number of cycles after each stimulus.

// File: rtl/autopoll_pkg.sv
package autopoll_pkg;
  localparam int NUM_CHAN = 2;
  localparam int CH_TX    = 0;
  localparam int CH_RX    = 1;
  localparam int PER_W    = 4;

  typedef struct packed {
    logic             long_cyc;
    logic [PER_W-1:0] period;
  } chan_cfg_t;

  localparam chan_cfg_t TX_RESET_CFG = '{long_cyc: 1'b0, period: 4'd0};
  localparam chan_cfg_t RX_RESET_CFG = '{long_cyc: 1'b0, period: 4'd1};
endpackage

// File: rtl/ap_cycle_prescaler.sv
module ap_cycle_prescaler #(
  parameter int NORM_BITS = 512,
  parameter int LONG_BITS = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic bit_tick,
  input  logic long_cyc,
  output logic unit_done
);
  localparam int CNT_W = (LONG_BITS > 1) ? $clog2(LONG_BITS) : 1;
  localparam logic [CNT_W-1:0] NORM_LAST = CNT_W'(NORM_BITS - 1);
  localparam logic [CNT_W-1:0] LONG_LAST = CNT_W'(LONG_BITS - 1);

  logic [CNT_W-1:0] bit_cnt;
  logic [CNT_W-1:0] last_val;

  assign last_val  = long_cyc ? LONG_LAST : NORM_LAST;
  assign unit_done = run && !clear && bit_tick && (bit_cnt == last_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
    end else if (clear || !run) begin
      bit_cnt <= '0;
    end else if (bit_tick) begin
      bit_cnt <= unit_done ? '0 : bit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ap_period_counter.sv
module ap_period_counter #(
  parameter int PER_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             unit_done,
  input  logic [PER_W-1:0] period,
  output logic             expire
);
  logic [PER_W-1:0] unit_cnt;

  assign expire = unit_done && (unit_cnt == period - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unit_cnt <= '0;
    end else if (clear) begin
      unit_cnt <= '0;
    end else if (unit_done) begin
      unit_cnt <= expire ? '0 : unit_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ap_req_hold.sv
module ap_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  output logic req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
    end else if (set) begin
      req <= 1'b1;
    end else if (ack) begin
      req <= 1'b0;
    end
  end
endmodule

// File: rtl/ap_channel.sv
module ap_channel
  import autopoll_pkg::*;
#(
  parameter int NORM_BITS = 512,
  parameter int LONG_BITS = 8192
) (
  input  logic      clk,
  input  logic      rst_n,
  input  chan_cfg_t cfg,
  input  logic      cfg_load,
  input  logic      bit_tick,
  input  logic      demand,
  input  logic      ack,
  output logic      req,
  output logic      expire
);
  logic restart;
  logic enabled;
  logic unit_done;

  assign restart = demand || cfg_load;
  assign enabled = (cfg.period != '0);

  ap_cycle_prescaler #(
    .NORM_BITS(NORM_BITS),
    .LONG_BITS(LONG_BITS)
  ) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (restart),
    .run      (enabled),
    .bit_tick (bit_tick),
    .long_cyc (cfg.long_cyc),
    .unit_done(unit_done)
  );

  ap_period_counter #(
    .PER_W(PER_W)
  ) u_per (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (restart),
    .unit_done(unit_done),
    .period   (cfg.period),
    .expire   (expire)
  );

  ap_req_hold u_req (
    .clk  (clk),
    .rst_n(rst_n),
    .set  (demand || expire),
    .ack  (ack),
    .req  (req)
  );
endmodule

// File: rtl/desc_autopoll_timer.sv
module desc_autopoll_timer
  import autopoll_pkg::*;
#(
  parameter int NORM_BITS = 512,
  parameter int LONG_BITS = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [3:0] cfg_tx_period,
  input  logic       cfg_tx_long,
  input  logic [3:0] cfg_rx_period,
  input  logic       cfg_rx_long,
  input  logic       bit_tick,
  input  logic       tx_demand,
  input  logic       rx_demand,
  output logic       tx_poll_req,
  input  logic       tx_poll_ack,
  output logic       rx_poll_req,
  input  logic       rx_poll_ack
);
  chan_cfg_t                       cfg_q    [NUM_CHAN];
  chan_cfg_t                       cfg_next [NUM_CHAN];
  logic [NUM_CHAN-1:0]             chan_demand;
  logic [NUM_CHAN-1:0]             chan_ack;
  logic [NUM_CHAN-1:0]             chan_req;
  logic [NUM_CHAN-1:0]             chan_expire;
  logic [NUM_CHAN-1:0][PER_W-1:0]  chan_period;

  assign cfg_next[CH_TX] = '{long_cyc: cfg_tx_long, period: cfg_tx_period};
  assign cfg_next[CH_RX] = '{long_cyc: cfg_rx_long, period: cfg_rx_period};

  assign chan_demand = {rx_demand, tx_demand};
  assign chan_ack    = {rx_poll_ack, tx_poll_ack};
  assign tx_poll_req = chan_req[CH_TX];
  assign rx_poll_req = chan_req[CH_RX];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q[CH_TX] <= TX_RESET_CFG;
      cfg_q[CH_RX] <= RX_RESET_CFG;
    end else if (cfg_we) begin
      cfg_q[CH_TX] <= cfg_next[CH_TX];
      cfg_q[CH_RX] <= cfg_next[CH_RX];
    end
  end

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_chan
    assign chan_period[g] = cfg_q[g].period;

    ap_channel #(
      .NORM_BITS(NORM_BITS),
      .LONG_BITS(LONG_BITS)
    ) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg     (cfg_q[g]),
      .cfg_load(cfg_we),
      .bit_tick(bit_tick),
      .demand  (chan_demand[g]),
      .ack     (chan_ack[g]),
      .req     (chan_req[g]),
      .expire  (chan_expire[g])
    );
  end
endmodule

// File: rtl/autopoll_checker.sv
module autopoll_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_tick,
  input logic [1:0] demand,
  input logic [1:0] ack,
  input logic [1:0] req,
  input logic [1:0] expire,
  input logic [1:0][3:0] period
);
  for (genvar g = 0; g < 2; g++) begin : g_chk
    p_expire_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      expire[g] |=> req[g]);

    p_zero_period_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (period[g] == 4'd0) |-> !expire[g]);

    p_demand_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      demand[g] |=> req[g]);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req[g] && !ack[g]) |=> req[g]);

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req[g] && ack[g] && !demand[g] && !expire[g]) |=> !req[g]);

    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!req[g] && !demand[g] && !expire[g]) |=> !req[g]);

    p_tick_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_tick |-> !expire[g]);
  end
endmodule

bind desc_autopoll_timer autopoll_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .bit_tick(bit_tick),
  .demand  (chan_demand),
  .ack     (chan_ack),
  .req     (chan_req),
  .expire  (chan_expire),
  .period  (chan_period)
);

// File: tb/sim_desc_autopoll_timer.sv
`timescale 1ns/1ps
module sim_desc_autopoll_timer;
  localparam int NB = 8;
  localparam int LB = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [3:0] tx_per = 4'd0, rx_per = 4'd0;
  logic tx_lg = 1'b0, rx_lg = 1'b0;
  logic bit_tick = 1'b0, tx_demand = 1'b0, rx_demand = 1'b0;
  logic tx_ack = 1'b0, rx_ack = 1'b0;
  logic tx_req, rx_req;

  always #2.5 clk = ~clk;

  desc_autopoll_timer #(.NORM_BITS(NB), .LONG_BITS(LB)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .cfg_tx_period(tx_per), .cfg_tx_long(tx_lg),
    .cfg_rx_period(rx_per), .cfg_rx_long(rx_lg),
    .bit_tick(bit_tick), .tx_demand(tx_demand), .rx_demand(rx_demand),
    .tx_poll_req(tx_req), .tx_poll_ack(tx_ack),
    .rx_poll_req(rx_req), .rx_poll_ack(rx_ack)
  );

  int checks = 0, errors = 0;
  int cyc = 0, tick_mode = 0, ack_mode = 0;
  string tag = "R1";

  // behavioural reference model, index 0 = TX, 1 = RX
  int m_per[2], m_long[2], m_pre[2], m_units[2], m_req[2], m_exp[2];
  int lim, dem, ak;
  bit fire;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_per[0] = 0; m_long[0] = 0; m_per[1] = 1; m_long[1] = 0;
      for (int c = 0; c < 2; c++) begin m_pre[c] = 0; m_units[c] = 0; m_req[c] = 0; end
    end else begin
      for (int c = 0; c < 2; c++) begin
        lim  = (m_long[c] != 0) ? LB : NB;
        dem  = (c == 0) ? int'(tx_demand) : int'(rx_demand);
        ak   = (c == 0) ? int'(tx_ack) : int'(rx_ack);
        fire = 1'b0;
        if (dem != 0 || cfg_we || m_per[c] == 0) begin
          m_pre[c] = 0; m_units[c] = 0;
        end else if (bit_tick) begin
          if (m_pre[c] == lim - 1) begin
            m_pre[c] = 0;
            if (m_units[c] == m_per[c] - 1) begin m_units[c] = 0; fire = 1'b1; end
            else m_units[c] = m_units[c] + 1;
          end else m_pre[c] = m_pre[c] + 1;
        end
        if (fire) m_exp[c] = m_exp[c] + 1;
        if (dem != 0 || fire) m_req[c] = 1;
        else if (ak != 0) m_req[c] = 0;
      end
      if (cfg_we) begin
        m_per[0] = int'(tx_per); m_long[0] = int'(tx_lg);
        m_per[1] = int'(rx_per); m_long[1] = int'(rx_lg);
      end
    end
  end

  task automatic chk(input bit ok, input string t, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", t, act, exp, cyc);
    end
  endtask

  int tx_rise = 0, rx_rise = 0;
  logic tx_prev = 1'b0, rx_prev = 1'b0;

  // one falling edge: compare with model, count rises, drive tick and ack
  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      if (rst_n) begin
        chk(tx_req == m_req[0][0], {tag, " TX model"}, int'(tx_req), m_req[0]);
        chk(rx_req == m_req[1][0], {tag, " RX model"}, int'(rx_req), m_req[1]);
      end
      if (tx_req && !tx_prev) tx_rise++;
      if (rx_req && !rx_prev) rx_rise++;
      tx_prev = tx_req; rx_prev = rx_req;
      bit_tick = (tick_mode == 0) ? 1'b1 : (tick_mode == 1) ? cyc[0] : 1'b0;
      tx_ack = (ack_mode == 2) ? tx_req : (ack_mode == 1) ? (tx_req && (cyc % 3 == 0)) : 1'b0;
      rx_ack = (ack_mode == 2) ? rx_req : (ack_mode == 1) ? (rx_req && (cyc % 3 == 0)) : 1'b0;
    end
  endtask

  task automatic write_cfg(input int tp, input int tl, input int rp, input int rl);
    tx_per = 4'(tp); tx_lg = tl[0]; rx_per = 4'(rp); rx_lg = rl[0];
    cfg_we = 1'b1;
    step(1);
    cfg_we = 1'b0;
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  int e0, e1, t0, r0, hi;
  initial begin
    step(3);
    chk(tx_req == 1'b0, "R1 tx_req in reset", int'(tx_req), 0);
    chk(rx_req == 1'b0, "R1 rx_req in reset", int'(rx_req), 0);
    rst_n = 1'b1;
    // reset config: RX period 1 normal -> expiry on 8th strobe
    tag = "R2";
    step(7);
    chk(rx_req == 1'b0, "R2 rx_req before 8 strobes", int'(rx_req), 0);
    step(1);
    chk(rx_req == 1'b1, "R2 rx_req after 8 strobes", int'(rx_req), 1);
    chk(tx_req == 1'b0, "R1 TX off after reset", int'(tx_req), 0);
    // unacknowledged: held, no extra requests
    tag = "R8"; r0 = rx_rise;
    step(40);
    chk(rx_req == 1'b1, "R7 request held without ack", int'(rx_req), 1);
    chk(rx_rise == r0, "R8 no queued requests", rx_rise - r0, 0);
    // accept it
    tag = "R7"; ack_mode = 2;
    step(2);
    chk(rx_req == 1'b0, "R7 request dropped after ack", int'(rx_req), 0);
    // TX period 3 long, RX period 2 normal
    tag = "R3"; ack_mode = 1;
    write_cfg(3, 1, 2, 0);
    t0 = tx_rise; r0 = rx_rise; e0 = m_exp[0]; e1 = m_exp[1];
    step(400);
    chk(tx_rise - t0 == 4, "R3 TX requests over 400 cycles (period 96)", tx_rise - t0, 4);
    chk(rx_rise - r0 == m_exp[1] - e1, "R4 RX requests equal expirations", rx_rise - r0, m_exp[1] - e1);
    chk(m_exp[1] - e1 == 25, "R4 RX expirations over 400 cycles (period 16)", m_exp[1] - e1, 25);
    // strobe every other cycle
    tag = "R10"; tick_mode = 1; r0 = rx_rise;
    step(320);
    chk(rx_rise - r0 >= 9 && rx_rise - r0 <= 11, "R10 RX rate halves with strobes", rx_rise - r0, 10);
    tick_mode = 2; r0 = rx_rise; t0 = tx_rise;
    step(200);
    chk(rx_rise == r0 && tx_rise == t0, "R10 no strobes no requests", rx_rise - r0, 0);
    // manual demand
    tag = "R6"; tick_mode = 0; ack_mode = 2;
    step(5);
    tx_demand = 1'b1;
    step(1);
    tx_demand = 1'b0;
    chk(tx_req == 1'b1, "R6 demand raises TX request next clock", int'(tx_req), 1);
    step(30);
    rx_demand = 1'b1;
    step(1);
    rx_demand = 1'b0;
    chk(rx_req == 1'b1, "R6 demand raises RX request next clock", int'(rx_req), 1);
    step(3);
    hi = 0;
    for (int i = 0; i < 11; i++) begin step(1); if (rx_req) hi++; end
    chk(hi == 0, "R6 demand restarted RX period", hi, 0);
    // config write restarts mid period
    tag = "R9";
    step(9);
    write_cfg(3, 1, 2, 0);
    hi = 0;
    for (int i = 0; i < 14; i++) begin step(1); if (rx_req) hi++; end
    chk(hi == 0, "R9 write restarted RX count", hi, 0);
    step(3);
    chk(rx_rise > 0, "R9 RX resumes after restart", rx_rise, 1);
    // both disabled
    tag = "R5";
    write_cfg(0, 0, 0, 1);
    step(2);
    t0 = tx_rise; r0 = rx_rise;
    step(300);
    chk(tx_rise == t0, "R5 TX period zero silent", tx_rise - t0, 0);
    chk(rx_rise == r0, "R5 RX period zero silent", rx_rise - r0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule